// File: doc/BRIEF.md
# Edge-Latching Bridge Interrupt Controller

This block gathers a parameterised set of interrupt sources and folds them into one interrupt line for an upstream controller. Each source is brought into the local clock domain by a synchroniser and reduced to a rising-edge event. Each event sets a sticky pending bit. A per-source enable selects which pending bits are allowed to drive the upstream line. That line stays high for as long as any bit is both pending and enabled.

Software reaches the block through a small 32-bit register port. The pending register sits at byte offset 0x00 and the enable register at byte offset 0x04. Pending bits latch whether or not they are enabled. Software acknowledges a bit by writing zero to it; a one in that position leaves the bit as it was. Before enabling a source, software clears its pending bit so that an event captured while the source was disabled does not reach the upstream line.

Top module: `edge_irq_bridge`

## Requirements
- R1: After reset the pending register, the enable register and `irq_o` are all zero.
- R2: When `src_i[k]` rises, pending bit k reads 1 after the third rising clock edge that follows the change, and not earlier.
- R3: A source held high sets its pending bit once only. After that bit is acknowledged it stays clear until the source falls and rises again.
- R4: A pending bit latches its event when its enable bit is 0. It does not drive `irq_o` while disabled.
- R5: A write to offset 0x00 clears every pending bit whose data bit is 0 and leaves unchanged every pending bit whose data bit is 1.
- R6: If an edge event for bit k reaches the pending register in the same cycle that a write of 0 to bit k is applied, bit k ends at 1.
- R7: A write to offset 0x04 loads the enable register. A read of offset 0x04 returns that value. An enable bit of 1 lets the matching pending bit reach `irq_o`.
- R8: `irq_o` equals the OR over all sources of (pending AND enable), delayed by one clock cycle.
- R9: Register bits at positions NUM_SRC and above read as zero and ignore writes, in both registers.
- R10: Reads of any offset other than 0x00 and 0x04 return zero, and writes to such offsets change nothing.
- R11: Writing zero to offset 0x04 and then zero to offset 0x00 leaves every source disabled and cleared, and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Asynchronous interrupt sources, rising edge active |
| reg_wr_i | input | 1 | Write strobe for the register port, one cycle per write |
| reg_addr_i | input | ADDR_W | Byte offset of the register being accessed |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt line to the upstream controller |

## Verification
A source change needs three clock edges to show in the pending register: two synchroniser flops, then the latch. It needs a fourth edge to show on `irq_o`. A register write takes effect at the edge that samples the strobe, and `irq_o` follows one edge after that. The bench drives and samples on falling edges. It counts falling edges from each stimulus and makes a "not yet" check one cycle before each result is due, as well as the check at the cycle the result is due. The collision case raises the write strobe on the falling edge just after the second clock edge, so that the write and the edge event reach the pending register on the same clock edge.

// File: rtl/irq_bridge_pkg.sv
package irq_bridge_pkg;
   // Register port geometry
   localparam int unsigned REG_W       = 32;
   localparam logic [7:0]  OFS_PENDING = 8'h00;
   localparam logic [7:0]  OFS_ENABLE  = 8'h04;

   // Which register an access selects
   typedef enum logic [1:0] {
      SEL_NONE    = 2'd0,
      SEL_PENDING = 2'd1,
      SEL_ENABLE  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/irq_bridge_edge_sync.sv
module irq_bridge_edge_sync #(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_SRC-1:0] rise_o
);
   localparam int unsigned PIPE_W = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("irq_bridge_edge_sync: SYNC_STAGES must be at least 2");
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [PIPE_W-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[PIPE_W-2:0], src_i[s]};
      end
      // newest synchronised sample high, previous sample low
      assign rise_o[s] = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
   end

   // An edge event lasts exactly one cycle, so a held level cannot re-arm a bit
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_bridge_regs.sv
module irq_bridge_regs #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_SRC-1:0]                 rise_i,
   input  irq_bridge_pkg::reg_sel_e           wr_sel_i,
   input  logic [irq_bridge_pkg::REG_W-1:0]   wdata_i,
   output logic [NUM_SRC-1:0]                 pending_o,
   output logic [NUM_SRC-1:0]                 enable_o
);
   import irq_bridge_pkg::*;

   logic [NUM_SRC-1:0] pending_q, pending_d;
   logic [NUM_SRC-1:0] enable_q;
   logic [NUM_SRC-1:0] wmask;
   logic               pend_wr, en_wr;

   assign wmask   = wdata_i[NUM_SRC-1:0];
   assign pend_wr = (wr_sel_i == SEL_PENDING);
   assign en_wr   = (wr_sel_i == SEL_ENABLE);

   // Acknowledge by writing zero; a new edge in the same cycle wins
   always_comb begin
      pending_d = pending_q;
      if (pend_wr) pending_d = pending_q & wmask;
      pending_d = pending_d | rise_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending_q <= '0;
      else        pending_q <= pending_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     enable_q <= '0;
      else if (en_wr) enable_q <= wmask;
   end

   assign pending_o = pending_q;
   assign enable_o  = enable_q;

   // Every edge event is visible in the pending register one cycle later
   assert_edge_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise_i) |=> ((pending_q & $past(rise_i)) == $past(rise_i)));
   // Pending bits never drop without a write to the pending register
   assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_wr) |=> ((pending_q & $past(pending_q)) == $past(pending_q)));
   // Enable register is only changed by its own write
   assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_wr) |=> $stable(enable_q));
endmodule

// File: rtl/irq_bridge_out.sv
module irq_bridge_out #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pending_i,
   input  logic [NUM_SRC-1:0] enable_i,
   output logic               irq_o
);
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(pending_i & enable_i);
   end

   assign irq_o = irq_q;

   assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(|(pending_i & enable_i)));
   assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> !$past(|(pending_i & enable_i)));
   // A disabled pending bit alone never holds the line up
   assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pending_i & enable_i) == '0) |=> !irq_q);
endmodule

// File: rtl/edge_irq_bridge.sv
module edge_irq_bridge #(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   output logic               irq_o
);
   import irq_bridge_pkg::*;

   localparam logic [ADDR_W-1:0] A_PENDING = ADDR_W'(OFS_PENDING);
   localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFS_ENABLE);

   if (NUM_SRC < 1 || NUM_SRC > REG_W) begin : g_bad_count
      $error("edge_irq_bridge: NUM_SRC must lie in 1..32");
   end
   if (ADDR_W < 3 || ADDR_W > 8) begin : g_bad_addr
      $error("edge_irq_bridge: ADDR_W must lie in 3..8");
   end

   logic [NUM_SRC-1:0] rise, pending, enable;
   reg_sel_e           sel, wr_sel;
   logic [REG_W-1:0]   pending_ext, enable_ext;

   always_comb begin
      if (reg_addr_i == A_PENDING)     sel = SEL_PENDING;
      else if (reg_addr_i == A_ENABLE) sel = SEL_ENABLE;
      else                             sel = SEL_NONE;
   end
   assign wr_sel = reg_wr_i ? sel : SEL_NONE;

   irq_bridge_edge_sync #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise));

   irq_bridge_regs #(.NUM_SRC(NUM_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .wr_sel_i(wr_sel),
      .wdata_i(reg_wdata_i), .pending_o(pending), .enable_o(enable));

   irq_bridge_out #(.NUM_SRC(NUM_SRC)) u_out (
      .clk(clk), .rst_n(rst_n), .pending_i(pending), .enable_i(enable), .irq_o(irq_o));

   // Zero-extend the source-wide registers onto the 32-bit port
   always_comb begin
      pending_ext = '0;
      enable_ext  = '0;
      pending_ext[NUM_SRC-1:0] = pending;
      enable_ext[NUM_SRC-1:0]  = enable;
   end

   always_comb begin
      case (sel)
         SEL_PENDING: reg_rdata_o = pending_ext;
         SEL_ENABLE:  reg_rdata_o = enable_ext;
         default:     reg_rdata_o = '0;
      endcase
   end

   assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (reg_rdata_o == '0));
endmodule

// File: tb/edge_irq_bridge_tb_top.sv
module edge_irq_bridge_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 6;
   localparam logic [31:0] ALL = (32'd1 << N) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src = '0;
   logic          wr = 1'b0;
   logic [3:0]    addr = 4'h0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;
   int            n_chk = 0;
   int            n_err = 0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_irq_bridge #(.NUM_SRC(N), .ADDR_W(4), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // raise the given sources, let them latch, drop them again
   task automatic pulse_src(input logic [N-1:0] v);
      src = v; ticks(3); src = '0; ticks(3);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic [31:0] exp_pend;
      ticks(3);
      rst_n = 1'b1;
      ticks(1);

      // R1 reset state
      rd_reg(4'h0, d); chk("R1 pending", d, 0);
      rd_reg(4'h4, d); chk("R1 enable", d, 0);
      chk("R1 irq", {31'd0, irq}, 0);

      // R2 per-source latency; R4 latching while disabled
      exp_pend = 0;
      for (int i = 0; i < N; i++) begin
         src[i] = 1'b1;
         ticks(2);
         rd_reg(4'h0, d); chk("R2 not yet", d, exp_pend);
         ticks(1);
         exp_pend |= (32'd1 << i);
         rd_reg(4'h0, d); chk("R2 latched", d, exp_pend);
         src[i] = 1'b0;
      end
      ticks(3);
      rd_reg(4'h0, d); chk("R4 latched while disabled", d, ALL);
      chk("R4 irq quiet", {31'd0, irq}, 0);

      // R7/R8 sweep every enable pattern against full pending
      for (int m = 0; m < (1 << N); m++) begin
         logic prev_irq;
         prev_irq = irq;
         wr_reg(4'h4, 32'(m));
         chk("R8 one cycle late", {31'd0, irq}, {31'd0, prev_irq});
         rd_reg(4'h4, d); chk("R7 enable readback", d, 32'(m));
         ticks(1);
         chk("R8 irq level", {31'd0, irq}, {31'd0, (m != 0)});
      end

      // R9 upper bits
      wr_reg(4'h4, 32'hFFFF_FFFF);
      rd_reg(4'h4, d); chk("R9 enable upper", d, ALL);
      wr_reg(4'h0, 32'hFFFF_FFFF);
      rd_reg(4'h0, d); chk("R9 pending upper", d, ALL);

      // R10 unmapped offsets
      wr_reg(4'h8, 32'h0);
      wr_reg(4'hC, 32'h0);
      rd_reg(4'h8, d); chk("R10 read 0x08", d, 0);
      rd_reg(4'hC, d); chk("R10 read 0x0C", d, 0);
      rd_reg(4'h0, d); chk("R10 pending kept", d, ALL);
      rd_reg(4'h4, d); chk("R10 enable kept", d, ALL);

      // R5 every acknowledge pattern
      for (int a = 0; a < (1 << N); a++) begin
         pulse_src('1);
         wr_reg(4'h0, 32'(a) | ~ALL);
         rd_reg(4'h0, d); chk("R5 ack pattern", d, 32'(a));
         ticks(1);
         chk("R5 irq after ack", {31'd0, irq}, {31'd0, (a != 0)});
      end

      // R3 held level
      wr_reg(4'h0, 0);
      src[2] = 1'b1; ticks(3);
      rd_reg(4'h0, d); chk("R3 first edge", d, 32'h4);
      wr_reg(4'h0, 0);
      ticks(5);
      rd_reg(4'h0, d); chk("R3 no re-set", d, 0);
      chk("R3 irq low", {31'd0, irq}, 0);
      src = '0; ticks(3);

      // R6 edge and acknowledge collide
      pulse_src(6'b000010);
      rd_reg(4'h0, d); chk("R6 precondition", d, 32'h2);
      src[1] = 1'b1;
      ticks(2);
      wr_reg(4'h0, 0);
      rd_reg(4'h0, d); chk("R6 set wins", d, 32'h2);
      src = '0; ticks(3);

      // R11 full quiesce
      wr_reg(4'h4, 0);
      wr_reg(4'h0, 0);
      ticks(1);
      rd_reg(4'h0, d); chk("R11 pending", d, 0);
      rd_reg(4'h4, d); chk("R11 enable", d, 0);
      chk("R11 irq", {31'd0, irq}, 0);

      finish_run();
   end
endmodule